// File: doc/BRIEF.md
# Prioritized Interrupt Pending Controller

This block keeps track of interrupt requests from a grid of sources. There are 32 priority levels and `SLOTS` source slots at each level, so a source is identified by its level and its slot. Devices raise and drop requests through two independent request ports, one that sets and one that clears. A processor core supplies its current priority level and three status flags. The block tells the core, combinationally, whether an interrupt can be taken now. It also serves a claim handshake that hands over the chosen source and its vector index.

The block stores a pending bit and an in-service bit for each source. It also keeps a 32-bit summary of the levels that have work pending, a cached highest pending level, and a software-interrupt summary. Each source has fixed configuration: the level is implied by its position, the trigger mode comes from a parameter mask, and the vector index is `VEC_BASE + level*SLOTS + slot`. Slot 0 at each level flagged in `SW_LEVELS` is a software source.

Claims run through a three-state machine:
- IDLE waits for `claim_req`.
- From IDLE, a request taken while `deliverable` is high goes to GRANT; any other request goes to REFUSE.
- GRANT and REFUSE each last one cycle, with `claim_ack` high, and then always return to IDLE. `claim_req` is ignored outside IDLE.

Top module: `ipc_ctrl`

## Requirements
- R1: `deliverable` is high only when all of these hold: the highest offerable level is strictly greater than `cur_ipl`, `int_en` is 1, `barrier_busy` is 0 and `entry_busy` is 0. A source is offerable when it is pending and not in service. A pending source at level 0 is never deliverable.
- R2: A request that cannot be delivered stays pending. It becomes deliverable as soon as the gating conditions are met, with no new raise needed.
- R3: `pend_summary` bit L is 1 exactly when at least one source at level L is pending. It changes on the clock edge that applies the update.
- R4: `top_level` holds the highest pending level, zero-extended to 8 bits, or 8'hFF when nothing is pending. It changes on the same edge as the pending bits, which covers raise, clear and claim.
- R5: A granted claim selects the highest offerable level and, within it, the lowest-numbered offerable slot. It reports `claim_level`, `claim_slot` and `claim_vector = VEC_BASE + level*SLOTS + slot`.
- R6: Granting an edge-triggered source clears its pending bit. Edge-triggered sources are those whose bit is 0 in `LVL_TRIG`; the bit index is `level*SLOTS + slot`.
- R7: Granting a level-triggered source, with its `LVL_TRIG` bit at 1, leaves it pending and marks it in service. While in service it is not offered. An `eos_vld` pulse naming the source clears the in-service mark.
- R8: Raising a software source sets bit L of `sw_summary`. Granting it or clearing it drops that bit.
- R9: When a raise and a clear name the same source in the same cycle, the source ends up pending.
- R10: A claim made while `deliverable` is 0 answers with `claim_none` = 1. It changes no pending, in-service or software-summary state.
- R11: `claim_ack` rises one cycle after a claim request is accepted in IDLE and stays high for exactly one cycle.
- R12: After reset, nothing is pending or in service, `pend_summary` = 0, `top_level` = 8'hFF, `sw_summary` = 0, and `claim_ack` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| raise_vld | input | 1 | Raise the request named by raise_lvl/raise_slot |
| raise_lvl | input | 5 | Level of the source to raise |
| raise_slot | input | SLOT_W | Slot of the source to raise |
| clr_vld | input | 1 | Clear the request named by clr_lvl/clr_slot |
| clr_lvl | input | 5 | Level of the source to clear |
| clr_slot | input | SLOT_W | Slot of the source to clear |
| eos_vld | input | 1 | End of service for the named source |
| eos_lvl | input | 5 | Level of the source leaving service |
| eos_slot | input | SLOT_W | Slot of the source leaving service |
| cur_ipl | input | 5 | Current priority level of the core |
| int_en | input | 1 | Interrupts enabled |
| barrier_busy | input | 1 | Serializing barrier in progress |
| entry_busy | input | 1 | Privileged entry sequence in progress |
| claim_req | input | 1 | Request to claim an interrupt |
| deliverable | output | 1 | An interrupt can be taken now |
| pend_summary | output | 32 | One bit per level with pending work |
| top_level | output | 8 | Cached highest pending level, 8'hFF if none |
| sw_summary | output | 32 | Software-interrupt summary, one bit per level |
| claim_ack | output | 1 | Claim answer valid (one cycle) |
| claim_none | output | 1 | Claim answered with no source |
| claim_level | output | 5 | Level of the granted source |
| claim_slot | output | SLOT_W | Slot of the granted source |
| claim_vector | output | VEC_W | Vector index of the granted source |

## Verification
Some properties are checked by assertions on every cycle:
- the one-cycle acknowledge pulse;
- a granted level always lying above the core level of the request cycle;
- the summary and cached level agreeing with each other, including the 8'hFF code;
- a raise always leaving its source pending, even against a simultaneous clear.

Other behaviour can only be shown by the bench's scenarios. That includes the slot order inside a level, and the different fates of edge and level sources after a grant. It also includes a request surviving every gating flag, refused claims leaving state untouched, and the software summary following raise and grant.

// File: rtl/ipc_pkg.sv
package ipc_pkg;
    localparam int LEVELS = 32;
    localparam int LVL_W  = 5;
    localparam logic [7:0] TOP_NONE = 8'hFF;

    typedef enum logic [1:0] {
        S_IDLE,
        S_GRANT,
        S_REFUSE
    } claim_st_t;
endpackage

// File: rtl/ipc_pick.sv
module ipc_pick
    import ipc_pkg::*;
#(
    parameter int SLOTS  = 4,
    parameter int SLOT_W = $clog2(SLOTS)
) (
    input  logic [LEVELS*SLOTS-1:0] avail,
    output logic                    any,
    output logic [LVL_W-1:0]        lvl,
    output logic [SLOT_W-1:0]       slot
);
    logic [SLOTS-1:0] row;

    // highest level with an offerable source
    always_comb begin
        any = 1'b0;
        lvl = '0;
        for (int l = 0; l < LEVELS; l++) begin
            if (|avail[l*SLOTS +: SLOTS]) begin
                any = 1'b1;
                lvl = LVL_W'(l);
            end
        end
    end

    // lowest slot inside that level
    always_comb begin
        row  = avail[lvl*SLOTS +: SLOTS];
        slot = '0;
        for (int s = SLOTS - 1; s >= 0; s--) begin
            if (row[s]) slot = SLOT_W'(s);
        end
    end
endmodule

// File: rtl/ipc_pend_store.sv
module ipc_pend_store
    import ipc_pkg::*;
#(
    parameter int                    SLOTS     = 4,
    parameter int                    SLOT_W    = $clog2(SLOTS),
    parameter logic [LEVELS*SLOTS-1:0] LVL_TRIG = '0,
    parameter logic [LEVELS-1:0]     SW_LEVELS = '0
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    raise_vld,
    input  logic [LVL_W+SLOT_W-1:0] raise_idx,
    input  logic                    clr_vld,
    input  logic [LVL_W+SLOT_W-1:0] clr_idx,
    input  logic                    eos_vld,
    input  logic [LVL_W+SLOT_W-1:0] eos_idx,
    input  logic                    claim_fire,
    input  logic [LVL_W+SLOT_W-1:0] claim_idx,
    output logic [LEVELS*SLOTS-1:0] pend_q,
    output logic [LEVELS*SLOTS-1:0] inserv_q,
    output logic [LEVELS-1:0]       summary_q,
    output logic [7:0]              top_q,
    output logic [LEVELS-1:0]       sw_q
);
    localparam int SRC_N = LEVELS * SLOTS;
    localparam int IDX_W = LVL_W + SLOT_W;

    logic [SRC_N-1:0]  pend_d, inserv_d;
    logic [LEVELS-1:0] sum_d, sw_d;
    logic [7:0]        top_d;

    function automatic logic is_sw(input logic [IDX_W-1:0] idx);
        return (idx[SLOT_W-1:0] == '0) && SW_LEVELS[idx[IDX_W-1:SLOT_W]];
    endfunction

    // order of updates: end of service, claim, clear, raise (raise wins)
    always_comb begin
        pend_d   = pend_q;
        inserv_d = inserv_q;
        sw_d     = sw_q;
        if (eos_vld) inserv_d[eos_idx] = 1'b0;
        if (claim_fire) begin
            if (LVL_TRIG[claim_idx]) inserv_d[claim_idx] = 1'b1;
            else                     pend_d[claim_idx]   = 1'b0;
            if (is_sw(claim_idx)) sw_d[claim_idx[IDX_W-1:SLOT_W]] = 1'b0;
        end
        if (clr_vld) begin
            pend_d[clr_idx] = 1'b0;
            if (is_sw(clr_idx)) sw_d[clr_idx[IDX_W-1:SLOT_W]] = 1'b0;
        end
        if (raise_vld) begin
            pend_d[raise_idx] = 1'b1;
            if (is_sw(raise_idx)) sw_d[raise_idx[IDX_W-1:SLOT_W]] = 1'b1;
        end
    end

    always_comb begin
        top_d = TOP_NONE;
        for (int l = 0; l < LEVELS; l++) begin
            sum_d[l] = |pend_d[l*SLOTS +: SLOTS];
            if (sum_d[l]) top_d = 8'(l);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pend_q    <= '0;
            inserv_q  <= '0;
            summary_q <= '0;
            top_q     <= TOP_NONE;
            sw_q      <= '0;
        end else begin
            pend_q    <= pend_d;
            inserv_q  <= inserv_d;
            summary_q <= sum_d;
            top_q     <= top_d;
            sw_q      <= sw_d;
        end
    end

    p_none_code_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (summary_q == '0) |-> (top_q == TOP_NONE));

    p_summary_top_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (top_q != TOP_NONE) |-> summary_q[top_q[LVL_W-1:0]]);

    p_raise_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
        raise_vld |=> pend_q[$past(raise_idx)]);
endmodule

// File: rtl/ipc_ctrl.sv
module ipc_ctrl
    import ipc_pkg::*;
#(
    parameter int                       SLOTS     = 4,
    parameter int                       SLOT_W    = $clog2(SLOTS),
    parameter int                       VEC_W     = 8,
    parameter logic [VEC_W-1:0]         VEC_BASE  = 8'h10,
    parameter logic [SLOTS-1:0]         TRIG_PAT  = 4'b0010,
    parameter logic [LEVELS*SLOTS-1:0]  LVL_TRIG  = {LEVELS{TRIG_PAT}},
    parameter logic [LEVELS-1:0]        SW_LEVELS = 32'h0000_FFFE
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               raise_vld,
    input  logic [4:0]         raise_lvl,
    input  logic [SLOT_W-1:0]  raise_slot,
    input  logic               clr_vld,
    input  logic [4:0]         clr_lvl,
    input  logic [SLOT_W-1:0]  clr_slot,
    input  logic               eos_vld,
    input  logic [4:0]         eos_lvl,
    input  logic [SLOT_W-1:0]  eos_slot,
    input  logic [4:0]         cur_ipl,
    input  logic               int_en,
    input  logic               barrier_busy,
    input  logic               entry_busy,
    input  logic               claim_req,
    output logic               deliverable,
    output logic [31:0]        pend_summary,
    output logic [7:0]         top_level,
    output logic [31:0]        sw_summary,
    output logic               claim_ack,
    output logic               claim_none,
    output logic [4:0]         claim_level,
    output logic [SLOT_W-1:0]  claim_slot,
    output logic [VEC_W-1:0]   claim_vector
);
    localparam int SRC_N = LEVELS * SLOTS;

    claim_st_t         state_q, state_d;
    logic [SRC_N-1:0]  pend, inserv;
    logic              p_any, claim_fire;
    logic [LVL_W-1:0]  p_lvl, g_lvl_q;
    logic [SLOT_W-1:0] p_slot, g_slot_q;
    logic [VEC_W-1:0]  g_vec_q;

    ipc_pend_store #(
        .SLOTS(SLOTS), .SLOT_W(SLOT_W), .LVL_TRIG(LVL_TRIG), .SW_LEVELS(SW_LEVELS)
    ) u_store (
        .clk(clk), .rst_n(rst_n),
        .raise_vld(raise_vld), .raise_idx({raise_lvl, raise_slot}),
        .clr_vld(clr_vld),     .clr_idx({clr_lvl, clr_slot}),
        .eos_vld(eos_vld),     .eos_idx({eos_lvl, eos_slot}),
        .claim_fire(claim_fire), .claim_idx({p_lvl, p_slot}),
        .pend_q(pend), .inserv_q(inserv),
        .summary_q(pend_summary), .top_q(top_level), .sw_q(sw_summary)
    );

    ipc_pick #(.SLOTS(SLOTS), .SLOT_W(SLOT_W)) u_pick (
        .avail(pend & ~inserv), .any(p_any), .lvl(p_lvl), .slot(p_slot)
    );

    assign deliverable = p_any && (p_lvl > cur_ipl) && int_en
                         && !barrier_busy && !entry_busy;
    assign claim_fire  = (state_q == S_IDLE) && claim_req && deliverable;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:   if (claim_req) state_d = deliverable ? S_GRANT : S_REFUSE;
            S_GRANT:  state_d = S_IDLE;
            S_REFUSE: state_d = S_IDLE;
            default:  state_d = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q  <= S_IDLE;
            g_lvl_q  <= '0;
            g_slot_q <= '0;
            g_vec_q  <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == S_IDLE && claim_req) begin
                g_lvl_q  <= claim_fire ? p_lvl : '0;
                g_slot_q <= claim_fire ? p_slot : '0;
                g_vec_q  <= claim_fire ? VEC_BASE + VEC_W'({p_lvl, p_slot}) : '0;
            end
        end
    end

    always_comb begin
        claim_ack    = (state_q != S_IDLE);
        claim_none   = (state_q == S_REFUSE);
        claim_level  = g_lvl_q;
        claim_slot   = g_slot_q;
        claim_vector = g_vec_q;
    end

    p_ack_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
        claim_ack |=> !claim_ack);

    p_grant_above_ipl_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (claim_ack && !claim_none) |-> (claim_level > $past(cur_ipl)));
endmodule

// File: tb/ipc_ctrl_test.sv
module ipc_ctrl_test;
    logic clk = 0;
    logic rst_n = 0;
    always #5 clk = ~clk;

    logic       raise_vld = 0, clr_vld = 0, eos_vld = 0, claim_req = 0;
    logic [4:0] raise_lvl = 0, clr_lvl = 0, eos_lvl = 0, cur_ipl = 0;
    logic [1:0] raise_slot = 0, clr_slot = 0, eos_slot = 0;
    logic       int_en = 1, barrier_busy = 0, entry_busy = 0;
    logic       deliverable, claim_ack, claim_none;
    logic [31:0] pend_summary, sw_summary;
    logic [7:0] top_level, claim_vector;
    logic [4:0] claim_level;
    logic [1:0] claim_slot;

    ipc_ctrl uut (
        .clk(clk), .rst_n(rst_n),
        .raise_vld(raise_vld), .raise_lvl(raise_lvl), .raise_slot(raise_slot),
        .clr_vld(clr_vld), .clr_lvl(clr_lvl), .clr_slot(clr_slot),
        .eos_vld(eos_vld), .eos_lvl(eos_lvl), .eos_slot(eos_slot),
        .cur_ipl(cur_ipl), .int_en(int_en), .barrier_busy(barrier_busy),
        .entry_busy(entry_busy), .claim_req(claim_req),
        .deliverable(deliverable), .pend_summary(pend_summary),
        .top_level(top_level), .sw_summary(sw_summary),
        .claim_ack(claim_ack), .claim_none(claim_none),
        .claim_level(claim_level), .claim_slot(claim_slot),
        .claim_vector(claim_vector)
    );

    int n_chk = 0, n_bad = 0;
    bit finished = 0;

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] vec_of(input logic [4:0] l, input logic [1:0] s);
        return 8'h10 + 8'(l) * 8'd4 + 8'(s);
    endfunction

    // op: 0 raise, 1 clear, 2 claim, 3 end of service
    typedef struct packed {
        logic [1:0] op;
        logic [4:0] lvl;
        logic [1:0] slot;
        logic [4:0] ipl;
        logic [7:0] top;
        logic       del;
        logic       none;
        logic [4:0] glvl;
        logic [1:0] gslot;
    } row_t;

    localparam int NROW = 15;
    localparam row_t TBL [NROW] = '{
        '{2'd0, 5'd5,  2'd2, 5'd0,  8'd5,   1'b1, 1'b0, 5'd0,  2'd0},
        '{2'd0, 5'd9,  2'd3, 5'd0,  8'd9,   1'b1, 1'b0, 5'd0,  2'd0},
        '{2'd0, 5'd9,  2'd1, 5'd0,  8'd9,   1'b1, 1'b0, 5'd0,  2'd0},
        '{2'd2, 5'd0,  2'd0, 5'd0,  8'd9,   1'b1, 1'b0, 5'd9,  2'd1},
        '{2'd2, 5'd0,  2'd0, 5'd0,  8'd9,   1'b1, 1'b0, 5'd9,  2'd3},
        '{2'd2, 5'd0,  2'd0, 5'd5,  8'd9,   1'b0, 1'b1, 5'd0,  2'd0},
        '{2'd3, 5'd9,  2'd1, 5'd5,  8'd9,   1'b1, 1'b0, 5'd0,  2'd0},
        '{2'd1, 5'd9,  2'd1, 5'd5,  8'd5,   1'b0, 1'b0, 5'd0,  2'd0},
        '{2'd2, 5'd0,  2'd0, 5'd4,  8'hFF,  1'b0, 1'b0, 5'd5,  2'd2},
        '{2'd0, 5'd3,  2'd0, 5'd0,  8'd3,   1'b1, 1'b0, 5'd0,  2'd0},
        '{2'd2, 5'd0,  2'd0, 5'd0,  8'hFF,  1'b0, 1'b0, 5'd3,  2'd0},
        '{2'd0, 5'd31, 2'd3, 5'd30, 8'd31,  1'b1, 1'b0, 5'd0,  2'd0},
        '{2'd0, 5'd0,  2'd0, 5'd0,  8'd31,  1'b1, 1'b0, 5'd0,  2'd0},
        '{2'd2, 5'd0,  2'd0, 5'd0,  8'd0,   1'b0, 1'b0, 5'd31, 2'd3},
        '{2'd1, 5'd0,  2'd0, 5'd0,  8'hFF,  1'b0, 1'b0, 5'd0,  2'd0}
    };

    // claim handshake: returns the answer seen on the ack cycle
    task automatic do_claim(output logic ack, output logic none,
                            output logic [4:0] l, output logic [1:0] s,
                            output logic [7:0] v);
        @(negedge clk) claim_req = 1;
        @(negedge clk);
        ack = claim_ack; none = claim_none; l = claim_level; s = claim_slot; v = claim_vector;
        claim_req = 0;
        @(negedge clk);
        chk("R11 ack drops", {63'd0, claim_ack}, 64'd0);
    endtask

    initial begin
        logic a, n;
        logic [4:0] gl;
        logic [1:0] gs;
        logic [7:0] gv;
        repeat (2) @(negedge clk);
        // R12 reset state
        chk("R12 summary", {32'd0, pend_summary}, 64'd0);
        chk("R12 top", {56'd0, top_level}, 64'hFF);
        chk("R12 sw", {32'd0, sw_summary}, 64'd0);
        chk("R12 ack", {63'd0, claim_ack}, 64'd0);
        chk("R12 deliverable", {63'd0, deliverable}, 64'd0);
        rst_n = 1;

        for (int i = 0; i < NROW; i++) begin
            cur_ipl = TBL[i].ipl;
            if (TBL[i].op == 2'd2) begin
                do_claim(a, n, gl, gs, gv);
                chk("R11 ack", {63'd0, a}, 64'd1);
                chk("R10 none", {63'd0, n}, {63'd0, TBL[i].none});
                if (!TBL[i].none) begin
                    chk("R5 level", {59'd0, gl}, {59'd0, TBL[i].glvl});
                    chk("R5 slot", {62'd0, gs}, {62'd0, TBL[i].gslot});
                    chk("R5 vector", {56'd0, gv}, {56'd0, vec_of(TBL[i].glvl, TBL[i].gslot)});
                end
            end else begin
                @(negedge clk);
                case (TBL[i].op)
                    2'd0: begin raise_vld = 1; raise_lvl = TBL[i].lvl; raise_slot = TBL[i].slot; end
                    2'd1: begin clr_vld = 1; clr_lvl = TBL[i].lvl; clr_slot = TBL[i].slot; end
                    default: begin eos_vld = 1; eos_lvl = TBL[i].lvl; eos_slot = TBL[i].slot; end
                endcase
                @(negedge clk);
                raise_vld = 0; clr_vld = 0; eos_vld = 0;
                @(negedge clk);
            end
            // R4 cached level, R6/R7 effect on pending, R1 gating
            chk("R4 top", {56'd0, top_level}, {56'd0, TBL[i].top});
            chk("R1 R6 R7 deliverable", {63'd0, deliverable}, {63'd0, TBL[i].del});
        end

        // gating by flags with a software source at level 7
        cur_ipl = 0; int_en = 0;
        @(negedge clk) begin raise_vld = 1; raise_lvl = 7; raise_slot = 0; end
        @(negedge clk) raise_vld = 0;
        @(negedge clk);
        chk("R3 summary", {32'd0, pend_summary}, 64'h80);
        chk("R8 sw raise", {32'd0, sw_summary}, 64'h80);
        chk("R1 int_en", {63'd0, deliverable}, 64'd0);
        do_claim(a, n, gl, gs, gv);
        chk("R10 refused", {63'd0, n}, 64'd1);
        chk("R10 summary kept", {32'd0, pend_summary}, 64'h80);
        chk("R10 sw kept", {32'd0, sw_summary}, 64'h80);
        int_en = 1; barrier_busy = 1; #1;
        chk("R1 barrier", {63'd0, deliverable}, 64'd0);
        barrier_busy = 0; entry_busy = 1; #1;
        chk("R1 entry", {63'd0, deliverable}, 64'd0);
        entry_busy = 0; #1;
        chk("R2 still pending", {63'd0, deliverable}, 64'd1);

        // raise and clear of the same source together
        @(negedge clk) begin
            raise_vld = 1; raise_lvl = 7; raise_slot = 2;
            clr_vld = 1; clr_lvl = 7; clr_slot = 2;
        end
        @(negedge clk) begin raise_vld = 0; clr_vld = 0; end
        do_claim(a, n, gl, gs, gv);
        chk("R5 lowest slot", {62'd0, gs}, 64'd0);
        chk("R8 sw cleared by grant", {32'd0, sw_summary}, 64'd0);
        do_claim(a, n, gl, gs, gv);
        chk("R9 raise won", {61'd0, n, gs}, {61'd0, 1'b0, 2'd2});
        chk("R6 edge cleared", {56'd0, top_level}, 64'hFF);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        finished = 1;
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end
endmodule